// File: doc/BRIEF.md
# Partition Key Access Guard

This block sits in front of a memory split into equal partitions and decides, request by request, whether an access may proceed. Each partition has a small protection key stored in an internal table, and the running context presents its own key alongside every request. The partition is chosen from the most significant address bits. The access is granted when the two keys agree. A context key of zero is the master key and passes every partition.

The verdict is combinational: grant or fault appears in the same cycle as the request strobe. The request side carries no back-pressure because the block never stalls, so a request is taken in every cycle in which `req_valid` is high. The key table is loaded through a separate write port. A write lands only when the supervisor-mode input is high. Any other write is discarded and flagged with a one-cycle privilege-fault pulse. After reset every key is zero, so only master-key contexts reach memory until software loads the table.

Top module: `mpk_guard`

## Requirements
- R1: The target partition is the value of the top PART_W bits of `req_addr`. The lower address bits do not affect the verdict.
- R2: With `req_valid` high and a non-zero context key, `acc_grant` is high exactly when `ctx_key` equals the stored key of the target partition.
- R3: With `req_valid` high and `ctx_key` equal to 0, `acc_grant` is high whatever key the target partition holds.
- R4: While `req_valid` is high, exactly one of `acc_grant` and `acc_fault` is high. While `req_valid` is low, both are low.
- R5: `acc_grant` and `acc_fault` respond in the same cycle as the request, with no register between the request inputs and the verdict.
- R6: A key-table write with `kt_wr_en` and `sup_mode` both high stores `kt_wr_key` at entry `kt_wr_idx` on the rising clock edge. An access in the same cycle as the write is still judged against the old key.
- R7: A key-table write with `sup_mode` low leaves every stored key unchanged.
- R8: `priv_fault` is high in exactly those cycles in which `kt_wr_en` is high and `sup_mode` is low.
- R9: After reset every stored key is 0.
- R10: The state of `req_write` (1 = write, 0 = read) has no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | Access direction, 1 = write |
| ctx_key | input | KEY_W | Key of the running context |
| sup_mode | input | 1 | Processor is in supervisor mode |
| kt_wr_en | input | 1 | Key-table write strobe |
| kt_wr_idx | input | PART_W | Partition whose key is written |
| kt_wr_key | input | KEY_W | New key value |
| acc_grant | output | 1 | Access allowed |
| acc_fault | output | 1 | Access refused |
| priv_fault | output | 1 | Key-table write attempted outside supervisor mode |

## Verification
The bench builds the block with its defaults: 16-bit addresses, 4 partition bits and 4-bit keys. With these values the full cross of 16 partitions and 16 context keys in both directions can be swept, first with the table as reset and again after every entry has been loaded with a distinct key. Because the table is small, the bench can read back every entry through the access path after a user-mode write attempt. It also checks a write and an access that fall in the same cycle.

// File: rtl/mpk_pkg.sv
package mpk_pkg;
  localparam int DEF_KEY_W  = 4;
  localparam int DEF_PART_W = 4;
  localparam int DEF_ADDR_W = 16;

  // Verdict of one key comparison; the all-zero key always passes.
  function automatic logic key_allows(input logic [DEF_KEY_W-1:0] ctx,
                                      input logic [DEF_KEY_W-1:0] part_key);
    return (ctx == '0) || (ctx == part_key);
  endfunction
endpackage

// File: rtl/mpk_part_decode.sv
module mpk_part_decode #(
  parameter int ADDR_W = 16,
  parameter int PART_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PART_W-1:0] part
);
  localparam int OFS_W = ADDR_W - PART_W;

  // The offset inside a partition plays no part in protection.
  logic [OFS_W-1:0] ofs_unused;

  assign part       = addr[ADDR_W-1:OFS_W];
  assign ofs_unused = addr[OFS_W-1:0];
endmodule

// File: rtl/mpk_key_table.sv
module mpk_key_table #(
  parameter int KEY_W  = 4,
  parameter int PART_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sup,
  input  logic [PART_W-1:0] wr_idx,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [PART_W-1:0] rd_idx,
  output logic [KEY_W-1:0]  rd_key,
  output logic              priv_fault
);
  localparam int NUM_PART = 1 << PART_W;

  logic             wr_ok;
  logic [KEY_W-1:0] key_q [NUM_PART];

  assign wr_ok      = wr_en && wr_sup;
  assign priv_fault = wr_en && !wr_sup;
  assign rd_key     = key_q[rd_idx];

  for (genvar i = 0; i < NUM_PART; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        key_q[i] <= '0;
      else if (wr_ok && (wr_idx == PART_W'(i)))
        key_q[i] <= wr_key;
    end

    // R6: a supervisor write lands in the addressed entry
    a_r6_sup_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sup && wr_idx == PART_W'(i)) |=> key_q[i] == $past(wr_key));

    // R7: a user-mode write leaves the entry untouched
    a_r7_user_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      priv_fault |=> $stable(key_q[i]));

    // R6: an entry changes only through an addressed supervisor write
    a_r6_no_stray_update: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sup && wr_idx == PART_W'(i)) |=> $stable(key_q[i]));
  end
endmodule

// File: rtl/mpk_key_match.sv
module mpk_key_match
  import mpk_pkg::*;
#(
  parameter int KEY_W = DEF_KEY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [KEY_W-1:0] ctx_key,
  input  logic [KEY_W-1:0] part_key,
  output logic             grant,
  output logic             fault
);
  logic allow;

  assign allow = (ctx_key == '0) || (ctx_key == part_key);
  assign grant = valid && allow;
  assign fault = valid && !allow;

  // R4: one verdict per request, none when idle
  a_r4_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $onehot({grant, fault}));
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !grant && !fault);
  // R3: the master key never faults
  a_r3_master_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ctx_key == '0) |-> grant);
  // R2: a key mismatch from a user context is refused
  a_r2_mismatch_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ctx_key != '0 && ctx_key != part_key) |-> fault);
endmodule

// File: rtl/mpk_guard.sv
module mpk_guard
  import mpk_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int PART_W = DEF_PART_W,
  parameter int KEY_W  = DEF_KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [KEY_W-1:0]  ctx_key,
  input  logic              sup_mode,
  input  logic              kt_wr_en,
  input  logic [PART_W-1:0] kt_wr_idx,
  input  logic [KEY_W-1:0]  kt_wr_key,
  output logic              acc_grant,
  output logic              acc_fault,
  output logic              priv_fault
);
  logic [PART_W-1:0] part;
  logic [KEY_W-1:0]  part_key;
  logic              dir_unused;

  // Reads and writes are judged alike (R10).
  assign dir_unused = req_write;

  mpk_part_decode #(.ADDR_W(ADDR_W), .PART_W(PART_W)) u_dec (
    .addr (req_addr),
    .part (part)
  );

  mpk_key_table #(.KEY_W(KEY_W), .PART_W(PART_W)) u_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (kt_wr_en),
    .wr_sup     (sup_mode),
    .wr_idx     (kt_wr_idx),
    .wr_key     (kt_wr_key),
    .rd_idx     (part),
    .rd_key     (part_key),
    .priv_fault (priv_fault)
  );

  mpk_key_match #(.KEY_W(KEY_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (req_valid),
    .ctx_key  (ctx_key),
    .part_key (part_key),
    .grant    (acc_grant),
    .fault    (acc_fault)
  );

  // R8: the privilege pulse coincides with a user-mode write attempt
  a_r8_priv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> kt_wr_en && !sup_mode);
  a_r8_sup_silent: assert property (@(posedge clk) disable iff (!rst_n)
    sup_mode |-> !priv_fault);
endmodule

// File: tb/sim_mpk_guard.sv
module sim_mpk_guard;
  localparam int ADDR_W = 16;
  localparam int PART_W = 4;
  localparam int KEY_W  = 4;
  localparam int NP     = 1 << PART_W;
  localparam int NK     = 1 << KEY_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic [KEY_W-1:0]  ctx_key = '0;
  logic              sup_mode = 1'b0;
  logic              kt_wr_en = 1'b0;
  logic [PART_W-1:0] kt_wr_idx = '0;
  logic [KEY_W-1:0]  kt_wr_key = '0;
  logic              acc_grant, acc_fault, priv_fault;

  int n_chk = 0;
  int n_bad = 0;
  int model [NP];

  always #4 clk = ~clk;

  mpk_guard #(.ADDR_W(ADDR_W), .PART_W(PART_W), .KEY_W(KEY_W)) u0 (
    .clk, .rst_n, .req_valid, .req_addr, .req_write, .ctx_key, .sup_mode,
    .kt_wr_en, .kt_wr_idx, .kt_wr_key, .acc_grant, .acc_fault, .priv_fault
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one access at the negative edge and judge it combinationally.
  task automatic probe(input string req, input int p, input int k, input int w,
                       input int lo);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'((p << (ADDR_W - PART_W)) | (lo & ((1 << (ADDR_W - PART_W)) - 1)));
    req_write = w[0];
    ctx_key   = KEY_W'(k);
    #1;
    chk(req, {30'd0, acc_grant, acc_fault},
        ((k == 0) || (k == model[p])) ? 2 : 1);
  endtask

  task automatic ktw(input int idx, input int key, input bit sup);
    @(negedge clk);
    req_valid = 1'b0;
    kt_wr_en  = 1'b1;
    kt_wr_idx = PART_W'(idx);
    kt_wr_key = KEY_W'(key);
    sup_mode  = sup;
    #1;
    chk("R8", priv_fault, sup ? 0 : 1);
    if (sup) model[idx] = key;
    @(negedge clk);
    kt_wr_en = 1'b0;
    sup_mode = 1'b0;
    #1;
    chk("R8", priv_fault, 0);
  endtask

  task automatic sweep(input string req);
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < NK; k++)
        for (int w = 0; w < 2; w++)
          probe(req, p, k, w, p * 977 + k * 131 + w * 53);
  endtask

  initial begin
    #20000000;
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R4", {30'd0, acc_grant, acc_fault}, 0);
    rst_n = 1'b1;

    // R9: reset keys are zero, only the master key and key 0 match
    sweep("R9");
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R4", {30'd0, acc_grant, acc_fault}, 0);

    // R6: load distinct keys in supervisor mode
    for (int p = 0; p < NP; p++) ktw(p, (p * 7 + 3) % NK, 1'b1);
    // R2 R3 R10 R1: full cross with loaded table, varied low bits
    sweep("R2");

    // R7: user-mode attempts leave the table unchanged
    for (int p = 0; p < NP; p++) ktw(p, (model[p] + 1) % NK, 1'b0);
    for (int p = 0; p < NP; p++) probe("R7", p, model[p], 0, 5);
    for (int p = 0; p < NP; p++) probe("R7", p, (model[p] + 1) % NK, 1, 9);

    // R6: a write and an access in the same cycle see the old key
    @(negedge clk);
    kt_wr_en  = 1'b1;
    sup_mode  = 1'b1;
    kt_wr_idx = PART_W'(5);
    kt_wr_key = KEY_W'(9);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(5 << (ADDR_W - PART_W));
    req_write = 1'b0;
    ctx_key   = KEY_W'(9);
    #1;
    chk("R6", acc_grant, (model[5] == 9) ? 1 : 0);
    chk("R5", acc_fault, (model[5] == 9) ? 0 : 1);
    @(negedge clk);
    kt_wr_en = 1'b0;
    sup_mode = 1'b0;
    model[5] = 9;
    #1;
    chk("R6", acc_grant, 1);
    // R1: same low bits, different partition
    probe("R1", 6, 9, 0, 0);
    probe("R1", 5, 9, 1, 12345);

    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R4", {30'd0, acc_grant, acc_fault}, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule